// File: doc/BRIEF.md
# Read Request Translator and Splitter

This block takes an inbound memory read request and turns it into a sequence of secondary-bus read sub-requests. Each request carries a start address, a length in bytes, a byte-enable mask, a request identifier and a one-bit flag from upstream address decoding. The flag says whether the address lies in a prefetchable window. From the flag and the shape of the byte-enable mask, the block picks one read command for the whole request: either a dword read or a block read.

The block then cuts the request into fragments. No fragment crosses a 128-byte address boundary. The first fragment runs up to the next boundary, and each later fragment covers a full 128 bytes, except the final one. Every fragment is tagged with the parent identifier, a running index and a last flag. For non-prefetchable requests the caller's byte enables are carried exactly, so the target sees no bytes beyond those asked for. While fragments are still being handed out, the input side stays not-ready.

Top module: `rrs_read_splitter`

## Requirements
- R1: When `req_pref` is 0 and `req_be` is non-contiguous, every fragment carries `frag_cmd` = 0 (dword read).
- R2: When `req_pref` is 1, or `req_be` is contiguous, every fragment carries `frag_cmd` = 1 (block read). A mask is contiguous when its set bits form one unbroken run; an all-zero mask counts as contiguous.
- R3: The first fragment's length is the smaller of the request length and the distance from the start address to the next multiple of 128. Each later fragment is 128 bytes, except the final one, which carries the rest. No fragment crosses a 128-byte boundary.
- R4: Fragment addresses follow one another without gap or overlap, starting at `req_addr`, and the fragment lengths add up to `req_len`. Every fragment except the last ends exactly on a 128-byte boundary.
- R5: For a non-prefetchable request, `frag_be` equals `req_be` on every fragment. For a prefetchable request, `frag_be` is all ones.
- R6: Each fragment carries `frag_id` = `req_id`. `frag_idx` is 0 for the first fragment and rises by one per fragment. `frag_last` is 1 only on the final fragment.
- R7: When a request is accepted (`req_valid` and `req_ready` both high at a clock edge), the first fragment is valid from the next cycle. `req_ready` stays low until the final fragment has been accepted, and returns high in the cycle after that.
- R8: While `frag_valid` is high and `frag_ready` is low, all fragment outputs hold their values.
- R9: After a synchronous reset, `frag_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | AW (32) | Start byte address |
| req_len | input | LW (12) | Length in bytes |
| req_be | input | BEW (4) | Byte-enable mask |
| req_pref | input | 1 | Address lies in a prefetchable window |
| req_id | input | IDW (8) | Parent request identifier |
| frag_valid | output | 1 | Fragment present |
| frag_ready | input | 1 | Downstream takes the fragment |
| frag_addr | output | AW (32) | Fragment start address |
| frag_len | output | OFFW+1 (8) | Fragment length in bytes |
| frag_cmd | output | 1 | 0 dword read, 1 block read |
| frag_be | output | BEW (4) | Fragment byte enables |
| frag_id | output | IDW (8) | Copy of the parent identifier |
| frag_idx | output | LW-OFFW+1 (6) | Fragment index within the request |
| frag_last | output | 1 | Final fragment of the request |

## Verification
The hardest cases to reach are where the start offset and the length meet at a boundary. Examples are a request that ends exactly on a 128-byte multiple, a one-byte request at offset 127, and the longest request starting one byte short of a boundary. In these cases the last-fragment decision and the length of the first fragment interact. The stimulus sweeps start offsets across the 128-byte window against a stepped range of lengths, adds the maximum length at the worst offset, and stalls `frag_ready` for varying stretches so that the hold behaviour is exercised mid-request. A separate sweep covers all sixteen masks under both window types to reach every command choice.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  typedef enum logic {
    RD_DWORD = 1'b0,
    RD_BLOCK = 1'b1
  } rd_cmd_e;
endpackage

// File: rtl/rrs_be_contig.sv
// Flags whether the set bits of a byte-enable mask form a single run.
module rrs_be_contig #(
  parameter int BEW = 4
) (
  input  logic [BEW-1:0] be,
  output logic           contig
);
  localparam int CW = $clog2(BEW) + 1;

  logic [CW-1:0] runs;
  logic          prev;

  always_comb begin
    runs = '0;
    prev = 1'b0;
    for (int i = 0; i < BEW; i++) begin
      if (be[i] && !prev) runs = runs + CW'(1);
      prev = be[i];
    end
    contig = (runs <= CW'(1));
  end
endmodule

// File: rtl/rrs_frag_len.sv
// Length of the next piece: the remainder, clipped at the next aligned boundary.
module rrs_frag_len #(
  parameter int AW         = 32,
  parameter int LW         = 12,
  parameter int FRAG_BYTES = 128,
  parameter int FLW        = 8
) (
  input  logic [AW-1:0]  addr,
  input  logic [LW-1:0]  remain,
  output logic [FLW-1:0] len
);
  localparam int OFFW = $clog2(FRAG_BYTES);

  logic [LW:0] room;

  always_comb begin
    room = (LW+1)'(FRAG_BYTES) - (LW+1)'(addr[OFFW-1:0]);
    if ({1'b0, remain} < room) len = FLW'(remain);
    else                       len = FLW'(room);
  end
endmodule

// File: rtl/rrs_read_splitter.sv
module rrs_read_splitter
  import rrs_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LW         = 12,
  parameter int BEW        = 4,
  parameter int IDW        = 8,
  parameter int FRAG_BYTES = 128,
  localparam int OFFW      = $clog2(FRAG_BYTES),
  localparam int FLW       = OFFW + 1,
  localparam int IXW       = LW - OFFW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic [LW-1:0]   req_len,
  input  logic [BEW-1:0]  req_be,
  input  logic            req_pref,
  input  logic [IDW-1:0]  req_id,
  output logic            frag_valid,
  input  logic            frag_ready,
  output logic [AW-1:0]   frag_addr,
  output logic [FLW-1:0]  frag_len,
  output logic            frag_cmd,
  output logic [BEW-1:0]  frag_be,
  output logic [IDW-1:0]  frag_id,
  output logic [IXW-1:0]  frag_idx,
  output logic            frag_last
);

  logic           be_contig;
  logic [FLW-1:0] first_len;
  logic [FLW-1:0] nxt_len;
  logic [AW-1:0]  nxt_addr;
  logic [LW-1:0]  remain_q;
  rd_cmd_e        cmd_sel;

  rrs_be_contig #(.BEW(BEW)) u_contig (
    .be     (req_be),
    .contig (be_contig)
  );

  rrs_frag_len #(.AW(AW), .LW(LW), .FRAG_BYTES(FRAG_BYTES), .FLW(FLW)) u_first (
    .addr   (req_addr),
    .remain (req_len),
    .len    (first_len)
  );

  assign nxt_addr = frag_addr + AW'(frag_len);

  rrs_frag_len #(.AW(AW), .LW(LW), .FRAG_BYTES(FRAG_BYTES), .FLW(FLW)) u_next (
    .addr   (nxt_addr),
    .remain (remain_q),
    .len    (nxt_len)
  );

  assign cmd_sel   = (req_pref || be_contig) ? RD_BLOCK : RD_DWORD;
  assign req_ready = !frag_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      frag_valid <= 1'b0;
      frag_addr  <= '0;
      frag_len   <= '0;
      frag_cmd   <= 1'b0;
      frag_be    <= '0;
      frag_id    <= '0;
      frag_idx   <= '0;
      frag_last  <= 1'b0;
      remain_q   <= '0;
    end else if (!frag_valid) begin
      if (req_valid) begin
        frag_valid <= 1'b1;
        frag_addr  <= req_addr;
        frag_len   <= first_len;
        frag_cmd   <= cmd_sel;
        frag_be    <= req_pref ? {BEW{1'b1}} : req_be;
        frag_id    <= req_id;
        frag_idx   <= '0;
        remain_q   <= req_len - LW'(first_len);
        frag_last  <= (req_len == LW'(first_len));
      end
    end else if (frag_ready) begin
      if (frag_last) begin
        frag_valid <= 1'b0;
      end else begin
        frag_addr  <= nxt_addr;
        frag_len   <= nxt_len;
        frag_idx   <= frag_idx + IXW'(1);
        remain_q   <= remain_q - LW'(nxt_len);
        frag_last  <= (remain_q == LW'(nxt_len));
      end
    end
  end

  // Fragment never spills past an aligned boundary.
  assert_no_cross_R3: assert property (@(posedge clk) disable iff (rst)
    frag_valid |-> ((FLW+1)'(frag_addr[OFFW-1:0]) + (FLW+1)'(frag_len) <= (FLW+1)'(FRAG_BYTES)));

  // Any fragment before the last ends exactly on a boundary.
  assert_mid_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    (frag_valid && !frag_last) |-> ((FLW+1)'(frag_addr[OFFW-1:0]) + (FLW+1)'(frag_len) == (FLW+1)'(FRAG_BYTES)));

  assert_idx_step_R6: assert property (@(posedge clk) disable iff (rst)
    (frag_valid && frag_ready && !frag_last) |=> (frag_valid && frag_idx == $past(frag_idx) + IXW'(1)));

  assert_first_frag_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (frag_valid && frag_idx == '0 && frag_addr == $past(req_addr)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (frag_valid && !frag_ready) |=> (frag_valid && $stable(frag_addr) && $stable(frag_len) &&
                                    $stable(frag_idx) && $stable(frag_last) && $stable(frag_be)));

  assert_pref_be_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_pref) |=> (frag_be == {BEW{1'b1}} && frag_cmd == RD_BLOCK));

endmodule

// File: tb/sim_rrs_read_splitter.sv
module sim_rrs_read_splitter;
  localparam int AW = 32, LW = 12, BEW = 4, IDW = 8, FB = 128;
  localparam int FLW = 8, IXW = 6;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_pref = 0, frag_ready = 0;
  logic req_ready;
  logic [AW-1:0] req_addr = 0;
  logic [LW-1:0] req_len = 0;
  logic [BEW-1:0] req_be = 0;
  logic [IDW-1:0] req_id = 0;
  logic frag_valid, frag_cmd, frag_last;
  logic [AW-1:0] frag_addr;
  logic [FLW-1:0] frag_len;
  logic [BEW-1:0] frag_be;
  logic [IDW-1:0] frag_id;
  logic [IXW-1:0] frag_idx;

  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  rrs_read_splitter u0 (.*);

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic contig_ref(input logic [BEW-1:0] m);
    logic [BEW-1:0] s = m;
    if (m == 0) return 1'b1;
    while (!s[0]) s = s >> 1;
    return ((s & (s + 1'b1)) == 0);
  endfunction

  task automatic run_req(input int addr, input int len, input logic [3:0] be,
                         input logic pref, input logic [7:0] id);
    int a, r, idx, chunk, stall;
    logic ecmd;
    logic [BEW-1:0] ebe;
    ecmd = pref || contig_ref(be);
    ebe  = pref ? 4'hF : be;
    @(negedge clk);
    req_valid = 1; req_addr = addr; req_len = LW'(len); req_be = be;
    req_pref = pref; req_id = id; frag_ready = 0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(frag_valid && !req_ready, "R7 first fragment after accept", {frag_valid, req_ready}, 2'b10);
    a = addr; r = len; idx = 0;
    do begin
      chunk = FB - (a % FB);
      if (chunk > r) chunk = r;
      stall = (idx + len) % 3;
      repeat (stall) begin
        frag_ready = 0;
        @(negedge clk);
        chk(frag_valid && frag_addr == AW'(a) && frag_len == FLW'(chunk) &&
            frag_idx == IXW'(idx), "R8 hold during stall", frag_addr, a);
      end
      frag_ready = 1;
      chk(frag_len == FLW'(chunk), "R3 length", frag_len, chunk);
      chk(frag_addr == AW'(a), "R4 address", frag_addr, a);
      chk(frag_cmd == ecmd, ecmd ? "R2 block cmd" : "R1 dword cmd", frag_cmd, ecmd);
      chk(frag_be == ebe, "R5 byte enables", frag_be, ebe);
      chk(frag_id == id && frag_idx == IXW'(idx) && frag_last == (r == chunk),
          "R6 tag", {frag_id, frag_idx, frag_last}, {id, 6'(idx), r == chunk});
      chk(!req_ready, "R7 busy", req_ready, 0);
      @(negedge clk);
      a += chunk; r -= chunk; idx++;
    end while (r > 0);
    frag_ready = 0;
    chk(!frag_valid && req_ready, "R7 idle after last", {frag_valid, req_ready}, 2'b01);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!frag_valid && req_ready, "R9 reset state", {frag_valid, req_ready}, 2'b01);
    // every mask under both window types
    for (int p = 0; p < 2; p++)
      for (int m = 0; m < 16; m++)
        run_req(32'h100 + m, 4, 4'(m), 1'(p), 8'(m + 16 * p));
    // offsets across the window versus lengths
    for (int off = 0; off < FB; off += 9)
      for (int len = 1; len <= 600; len += 11)
        run_req(32'h2000 + off, len, 4'b0101, 1'((off + len) & 1), 8'(len));
    // boundary corners
    run_req(32'h7F, 1, 4'b1001, 0, 8'hA1);
    run_req(32'h80, 128, 4'b0110, 0, 8'hA2);
    run_req(32'h81, 255, 4'b1111, 1, 8'hA3);
    run_req(32'h1000, 256, 4'b1011, 0, 8'hA4);
    run_req(32'h7F, 4095, 4'b0001, 0, 8'hA5);
    run_req(32'hFFFF_FF00, 129, 4'b0000, 0, 8'hA6);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule